// File: doc/BRIEF.md
# Alternating-Reference Hysteresis Input Sampler

This block gives a bank of isolated digital inputs hysteresis by moving the reference they are compared against, instead of debouncing them in logic. The inputs are sensed by comparators that share one reference voltage. That reference comes from an external DAC, and this block drives the DAC's code and its load strobe. While hysteresis is on, the block swaps the reference between a programmed low code and a programmed high code once per divider period, which is 2 kHz at the default setting. After each swap it waits a settling time and then captures the whole input vector.

Every capture is paired with the capture taken just before it, which was made at the other reference level. A bit that reads 1 in both captures becomes 1, and a bit that reads 0 in both becomes 0. A bit that disagrees keeps its last filtered value. As a result, a line that has gone high stays high while its voltage sits between the two references. With hysteresis off, the reference rests at the low code and each capture is copied straight to the output. Two 10-bit level registers hold the codes. A 32-bit configuration word carries the enable bit and the hysteresis bit.

Top module: `ref_toggle_sampler`

## Requirements
- R1: When bit 0 of `cfg_word` is 0, `filt_out` is all zeros from the first clock edge that sees that value.
- R2: While bit 0 of `cfg_word` is 0, `dac_code` returns to the low level code and stays there, and `dac_load` pulses only when `dac_code` changes. All bits of `cfg_word` other than 0 and 18 are ignored.
- R3: After reset the low level is 0x100 and the high level is 0x300. Also after reset, `filt_out` is 0, `dac_code` is 0x100 and `dac_load` is 0.
- R4: With bit 0 set and bit 18 clear, every reference switch loads the low level code, and each capture is copied unchanged to `filt_out`.
- R5: With bits 0 and 18 set, successive switches alternate between the high and low codes. The first switch after idle or after a non-hysteresis period goes to the high code. Each switch is a one-cycle `dac_load` pulse with the new `dac_code` in the same cycle.
- R6: In hysteresis mode, an output bit becomes the captured value when the current capture and the previous capture agree. When they disagree, the bit keeps its previous value.
- R7: The first capture after hysteresis mode starts has no partner capture and leaves `filt_out` unchanged.
- R8: The capture is taken at the clock edge that ends the cycle coming SETTLE_CYC cycles after the `dac_load` cycle.
- R9: `lvl_wr_lo` and `lvl_wr_hi` write `lvl_wdata` into the low and high level registers. A write changes `dac_code` only at the next reference switch, and `dac_code` never changes without `dac_load`.
- R10: While enabled, reference switches occur exactly DIV_CYC clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word: bit 0 enables the block, bit 18 enables hysteresis |
| lvl_wr_lo | input | 1 | Write strobe for the low level register |
| lvl_wr_hi | input | 1 | Write strobe for the high level register |
| lvl_wdata | input | CODE_W | Level code to write |
| raw_in | input | N_IN | Comparator outputs of the inputs |
| filt_out | output | N_IN | Filtered input states |
| dac_code | output | CODE_W | Reference code for the external DAC |
| dac_load | output | 1 | One-cycle load strobe for `dac_code` |

## Verification
The bench builds the block with DIV_CYC = 20 and SETTLE_CYC = 4. The short period lets dozens of reference windows run in a few thousand cycles, so a full sequence of alternating high and low captures can be walked, including hold cases and release cases. The four-cycle settle is long enough that the bench can present the correct input pattern for exactly one cycle, with different patterns on either side. This shows that the capture lands on the stated edge and not one cycle early or late. The same settings also make switch spacing, deferred level writes and idle behaviour quick to observe.

// File: rtl/hyst_pkg.sv
package hyst_pkg;
    // Configuration word bit positions
    localparam int CFG_RUN_BIT  = 0;
    localparam int CFG_HYST_BIT = 18;

    typedef enum logic { PH_LO = 1'b0, PH_HI = 1'b1 } phase_e;
    typedef enum logic { ST_WAIT = 1'b0, ST_SETTLE = 1'b1 } seq_e;
endpackage

// File: rtl/rate_div.sv
module rate_div #(
    parameter int DIV_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (DIV_CYC > 1) ? $clog2(DIV_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: counter never passes the terminal value
    assert_cnt_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/level_bank.sv
module level_bank #(
    parameter int              CODE_W = 10,
    parameter logic [CODE_W-1:0] LO_RST = 10'h100,
    parameter logic [CODE_W-1:0] HI_RST = 10'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [CODE_W-1:0] wdata,
    output logic [CODE_W-1:0] lo_lvl,
    output logic [CODE_W-1:0] hi_lvl
);
    logic [CODE_W-1:0] lo_d, lo_q, hi_d, hi_q;

    always_comb begin
        lo_d = wr_lo ? wdata : lo_q;
        hi_d = wr_hi ? wdata : hi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= LO_RST;
            hi_q <= HI_RST;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign lo_lvl = lo_q;
    assign hi_lvl = hi_q;

    // R9: level only changes through its write strobe
    assert_lo_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(lo_q));
endmodule

// File: rtl/pair_vote.sv
module pair_vote #(
    parameter int N = 24
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] held,
    output logic [N-1:0] voted
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        assign voted[b] = (cur[b] == prev[b]) ? cur[b] : held[b];
    end
endmodule

// File: rtl/ref_toggle_sampler.sv
module ref_toggle_sampler
    import hyst_pkg::*;
#(
    parameter int N_IN       = 24,
    parameter int CODE_W     = 10,
    parameter int DIV_CYC    = 50000,
    parameter int SETTLE_CYC = 50,
    parameter logic [CODE_W-1:0] LO_RST = 10'h100,
    parameter logic [CODE_W-1:0] HI_RST = 10'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic              lvl_wr_lo,
    input  logic              lvl_wr_hi,
    input  logic [CODE_W-1:0] lvl_wdata,
    input  logic [N_IN-1:0]   raw_in,
    output logic [N_IN-1:0]   filt_out,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_load
);
    // DIV_CYC must exceed SETTLE_CYC + 1 so a capture ends before the next switch
    localparam int SET_W = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;

    typedef struct packed {
        phase_e            phase;
        seq_e              st;
        logic [SET_W-1:0]  settle;
        logic              prev_ok;
        logic [N_IN-1:0]   prev;
        logic [N_IN-1:0]   filt;
        logic [CODE_W-1:0] code;
        logic              load;
    } seq_t;

    logic run_en, hyst_en, tick, sample_fire, unused_cfg_bits;
    logic [CODE_W-1:0] lo_lvl, hi_lvl;
    logic [N_IN-1:0]   voted;
    phase_e            nxt_phase;
    seq_t              s_d, s_q;

    assign run_en          = cfg_word[CFG_RUN_BIT];
    assign hyst_en         = cfg_word[CFG_HYST_BIT];
    assign unused_cfg_bits = ^{cfg_word[31:CFG_HYST_BIT+1], cfg_word[CFG_HYST_BIT-1:CFG_RUN_BIT+1]};

    rate_div #(.DIV_CYC(DIV_CYC)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run_en), .tick(tick)
    );

    level_bank #(.CODE_W(CODE_W), .LO_RST(LO_RST), .HI_RST(HI_RST)) u_lvl (
        .clk(clk), .rst_n(rst_n), .wr_lo(lvl_wr_lo), .wr_hi(lvl_wr_hi),
        .wdata(lvl_wdata), .lo_lvl(lo_lvl), .hi_lvl(hi_lvl)
    );

    pair_vote #(.N(N_IN)) u_vote (
        .cur(raw_in), .prev(s_q.prev), .held(s_q.filt), .voted(voted)
    );

    always_comb begin
        s_d         = s_q;
        s_d.load    = 1'b0;
        sample_fire = 1'b0;
        nxt_phase   = PH_LO;
        if (!run_en) begin
            s_d.phase   = PH_LO;
            s_d.st      = ST_WAIT;
            s_d.settle  = '0;
            s_d.prev_ok = 1'b0;
            s_d.filt    = '0;
            s_d.code    = lo_lvl;
            s_d.load    = (s_q.code != lo_lvl);
        end else begin
            if (!hyst_en) s_d.prev_ok = 1'b0;
            case (s_q.st)
                ST_WAIT: begin
                    if (tick) begin
                        nxt_phase  = (hyst_en && s_q.phase == PH_LO) ? PH_HI : PH_LO;
                        s_d.phase  = nxt_phase;
                        s_d.code   = (nxt_phase == PH_HI) ? hi_lvl : lo_lvl;
                        s_d.load   = 1'b1;
                        s_d.st     = ST_SETTLE;
                        s_d.settle = SET_W'(SETTLE_CYC);
                    end
                end
                default: begin
                    if (s_q.settle == '0) begin
                        sample_fire = 1'b1;
                        s_d.st      = ST_WAIT;
                        if (!hyst_en) begin
                            s_d.filt = raw_in;
                        end else begin
                            if (s_q.prev_ok) s_d.filt = voted;
                            s_d.prev    = raw_in;
                            s_d.prev_ok = 1'b1;
                        end
                    end else begin
                        s_d.settle = s_q.settle - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.phase   <= PH_LO;
            s_q.st      <= ST_WAIT;
            s_q.code    <= LO_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign filt_out = s_q.filt;
    assign dac_code = s_q.code;
    assign dac_load = s_q.load;

    // R1: disabled block drives zeros
    assert_off_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (filt_out == '0));

    // R4: without hysteresis every switch uses the low code
    assert_plain_uses_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !hyst_en && tick) |=> (dac_load && dac_code == $past(lo_lvl)));

    // R5: with hysteresis each switch flips to the other level
    assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && hyst_en && tick) |=>
        (dac_load && dac_code == (($past(s_q.phase) == PH_LO) ? $past(hi_lvl) : $past(lo_lvl))));

    // R6: agreeing bits take the captured value
    assert_vote_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_fire && hyst_en && s_q.prev_ok) |=>
        (((filt_out ^ $past(raw_in)) & ~($past(raw_in) ^ $past(s_q.prev))) == '0));

    // R6: disagreeing bits keep their value
    assert_vote_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_fire && hyst_en && s_q.prev_ok) |=>
        (((filt_out ^ $past(filt_out)) & ($past(raw_in) ^ $past(s_q.prev))) == '0));

    // R7: first hysteresis capture changes nothing
    assert_first_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_fire && hyst_en && !s_q.prev_ok) |=> $stable(filt_out));

    // R9: code moves only together with its strobe
    assert_code_with_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load |-> $stable(dac_code));
endmodule

// File: tb/tb_ref_toggle_sampler.sv
module tb_ref_toggle_sampler;
    localparam int N   = 24;
    localparam int CW  = 10;
    localparam int DIV = 20;
    localparam int SET = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   cfg_word = '0;
    logic          lvl_wr_lo = 1'b0, lvl_wr_hi = 1'b0;
    logic [CW-1:0] lvl_wdata = '0;
    logic [N-1:0]  raw_in = '0;
    logic [N-1:0]  filt_out;
    logic [CW-1:0] dac_code;
    logic          dac_load;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    ref_toggle_sampler #(.N_IN(N), .CODE_W(CW), .DIV_CYC(DIV), .SETTLE_CYC(SET)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .lvl_wr_lo(lvl_wr_lo), .lvl_wr_hi(lvl_wr_hi), .lvl_wdata(lvl_wdata),
        .raw_in(raw_in), .filt_out(filt_out), .dac_code(dac_code), .dac_load(dac_load)
    );

    // {raw pattern for the window, expected filt_out after that window's capture}
    // windows alternate high, low, high, ... starting from the high code
    localparam logic [47:0] TBL [0:7] = '{
        {24'hFFF000, 24'h000000},
        {24'hFF0F00, 24'hFF0000},
        {24'h0F0F0F, 24'hFF0F00},
        {24'h0F0F0F, 24'h0F0F0F},
        {24'h000000, 24'h0F0F0F},
        {24'h000000, 24'h000000},
        {24'h123456, 24'h000000},
        {24'h123456, 24'h123456}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_load();
        do @(negedge clk); while (dac_load !== 1'b1);
    endtask

    task automatic write_lvl(input bit hi, input logic [CW-1:0] v);
        lvl_wdata = v;
        if (hi) lvl_wr_hi = 1'b1; else lvl_wr_lo = 1'b1;
        @(negedge clk);
        lvl_wr_hi = 1'b0;
        lvl_wr_lo = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R3: reset state
        chk("R3 filt reset", 32'(filt_out), 32'h0);
        chk("R3 code reset", 32'(dac_code), 32'h100);
        chk("R3 load reset", 32'(dac_load), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 idle no load", 32'(dac_load), 32'h0);

        // R5/R6/R3: hysteresis table walk with default levels
        cfg_word = 32'h0004_0001;
        for (int i = 0; i < 8; i++) begin
            wait_load();
            chk((i % 2 == 0) ? "R5 high code" : "R5 low code", 32'(dac_code),
                (i % 2 == 0) ? 32'h300 : 32'h100);
            if (i > 0) chk("R6 vote", 32'(filt_out), 32'(TBL[i-1][23:0]));
            raw_in = TBL[i][47:24];
        end
        wait_load();
        chk("R6 vote last", 32'(filt_out), 32'(TBL[7][23:0]));
        chk("R5 back to high", 32'(dac_code), 32'h300);

        // R9: level writes wait for the next switch
        write_lvl(1'b0, 10'h0AA);
        write_lvl(1'b1, 10'h3C0);
        repeat (2) @(negedge clk);
        chk("R9 code held", 32'(dac_code), 32'h300);
        wait_load();
        chk("R9 new low", 32'(dac_code), 32'h0AA);
        wait_load();
        chk("R9 new high", 32'(dac_code), 32'h3C0);

        // R10: switch spacing
        n = 0;
        do begin @(negedge clk); n++; end while (dac_load !== 1'b1);
        chk("R10 spacing", 32'(n), 32'(DIV));

        // R4: plain mode follows input directly, low code only
        cfg_word = 32'h0000_0001;
        raw_in = 24'hA5A5A5;
        wait_load();
        chk("R4 low code", 32'(dac_code), 32'h0AA);
        wait_load();
        chk("R4 direct", 32'(filt_out), 32'hA5A5A5);
        raw_in = 24'h5A5A5A;
        wait_load();
        chk("R4 direct no hold", 32'(filt_out), 32'h5A5A5A);
        chk("R4 low code again", 32'(dac_code), 32'h0AA);

        // R8: capture edge exactly SET cycles after the load cycle
        raw_in = 24'h111111;
        repeat (SET) @(negedge clk);
        raw_in = 24'h777777;
        @(negedge clk);
        raw_in = 24'h222222;
        chk("R8 capture edge", 32'(filt_out), 32'h777777);

        // R1/R2: disable with every other config bit set
        cfg_word = 32'hFFFB_FFFE;
        @(negedge clk);
        chk("R1 zeros", 32'(filt_out), 32'h0);
        repeat (3) @(negedge clk);
        chk("R2 idle low code", 32'(dac_code), 32'h0AA);
        n = 0;
        for (int k = 0; k < 3 * DIV; k++) begin
            @(negedge clk);
            if (dac_load) n++;
        end
        chk("R2 no strobes", 32'(n), 32'h0);
        chk("R1 still zero", 32'(filt_out), 32'h0);

        // R5/R7: restart hysteresis
        raw_in = 24'hFFFFFF;
        cfg_word = 32'h0004_0001;
        wait_load();
        chk("R5 first high", 32'(dac_code), 32'h3C0);
        wait_load();
        chk("R7 first capture holds", 32'(filt_out), 32'h0);
        wait_load();
        chk("R6 agree high", 32'(filt_out), 32'hFFFFFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule